// File: doc/BRIEF.md
# Banked Set-Associative Cache Lookup

This block is the lookup path of a set-associative cache whose sets are spread over independent banks. A request address is cut into tag, bank index, set index and line offset. The bank index picks a bank and the set index picks a set inside it. Every way of that set is read at once. Each way's stored tag is compared with the requested tag and the result is gated by that way's valid bit. On a hit the block returns the addressed word and byte. The data is chosen in three stages: first the line of the hitting way, then the word within that line, then the byte within that word. On a miss the block raises a request toward the next memory level, carrying the line-aligned address.

There are two request ports. Because the banks are separate arrays, both ports are served in the same cycle when they address different banks, and no cell needs a second port. When both ports address the same bank, port 0 is served and port 1 is told it is not ready. A fill port writes a tag and a whole line into a chosen way and marks that way valid. Reset invalidates every line.

The geometry is set by parameters. The defaults are 8 banks, 8 ways and a 64-bit address, with the line and set count scaled down for simulation. Setting 128-byte lines and 64 sets per bank gives the full 512-set, 1 KB-per-set arrangement without changing any field-split logic.

Top module: `bcl_top`

## Requirements
- R1: Address fields, from least significant: the line offset takes log2(LINE_BYTES) bits, the set index takes log2(SETS_PER_BANK) bits, the bank index takes log2(NUM_BANKS) bits, and the tag is all remaining upper bits. The default split is 4/2/3/55 bits. Addresses that differ only in bank or set bits map to different lines.
- R2: A way hits only when its valid bit is set and its stored tag equals the requested tag in every bit. If no way hits, the response is a miss.
- R3: On a hit, the word output is the aligned word of WORD_BYTES bytes that contains the offset, and the byte output is the byte at the offset. Within a line, byte k occupies bits [8k+7:8k] (little-endian). The word index is the offset's upper bits and the byte index within the word is the offset's lower log2(WORD_BYTES) bits.
- R4: On a miss, the word and byte outputs are zero. A miss request is raised in the same cycle as the response, carrying the request address with its offset bits cleared.
- R5: Every response is exactly one of a hit or a miss request. When there is no response, neither the hit flag nor the miss request is raised.
- R6: A response appears exactly one clock after an accepted request. No response appears in a cycle that follows no accepted request.
- R7: Two requests that address different banks are both accepted in the same cycle, and both respond in the next cycle.
- R8: When both ports address the same bank in one cycle, port 0 is accepted. Port 1's ready is low in that cycle and port 1 gives no response for it. Port 1's ready is high in every other case.
- R9: A fill writes the tag, the line and the valid bit of the given way in the addressed bank and set. Lookups see the fill from the next cycle onward. A lookup in the same cycle as the fill sees the earlier contents.
- R10: When more than one way hits, the multi-hit flag is raised with the hit, and the data comes from the lowest-numbered hitting way.
- R11: Reset clears every valid bit and every response output. After reset, every lookup misses until a fill is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq0_valid | input | 1 | Port 0 request valid |
| rq0_addr | input | ADDR_W | Port 0 request address |
| rq1_valid | input | 1 | Port 1 request valid |
| rq1_addr | input | ADDR_W | Port 1 request address |
| rq1_ready | output | 1 | Port 1 accepted this cycle (low on a bank clash) |
| rs0_valid | output | 1 | Port 0 response valid |
| rs0_hit | output | 1 | Port 0 hit |
| rs0_multi | output | 1 | Port 0 more than one way matched |
| rs0_word | output | WORD_BYTES*8 | Port 0 selected word |
| rs0_byte | output | 8 | Port 0 selected byte |
| mq0_valid | output | 1 | Port 0 miss request to next level |
| mq0_addr | output | ADDR_W | Port 0 line-aligned miss address |
| rs1_valid | output | 1 | Port 1 response valid |
| rs1_hit | output | 1 | Port 1 hit |
| rs1_multi | output | 1 | Port 1 more than one way matched |
| rs1_word | output | WORD_BYTES*8 | Port 1 selected word |
| rs1_byte | output | 8 | Port 1 selected byte |
| mq1_valid | output | 1 | Port 1 miss request to next level |
| mq1_addr | output | ADDR_W | Port 1 line-aligned miss address |
| fl_valid | input | 1 | Fill write enable |
| fl_addr | input | ADDR_W | Fill address (tag, bank, set) |
| fl_way | input | log2(WAYS) | Fill target way |
| fl_line | input | LINE_BYTES*8 | Fill line data |

## Verification
Port 1's ready is combinational, so it is checked in the same cycle the requests are driven. Hit, multi-hit, word, byte and miss request all pass through one register and are due one rising edge after the request. The bench drives each request at a falling edge, checks ready shortly after, and compares the responses at the next falling edge. A fill updates the bench's model only after the prediction for that same cycle is made, which matches the rule that a fill becomes visible one cycle later.

// File: rtl/bcl_pkg.sv
`timescale 1ns/1ps
package bcl_pkg;

    localparam int DEF_ADDR_W     = 64;
    localparam int DEF_BANKS      = 8;
    localparam int DEF_SETS       = 4;
    localparam int DEF_WAYS       = 8;
    localparam int DEF_LINE_BYTES = 16;
    localparam int DEF_WORD_BYTES = 4;
    localparam int NUM_PORTS      = 2;

    // Which request port owns a bank's read port in a cycle.
    typedef enum logic [1:0] {
        GRANT_NONE = 2'd0,
        GRANT_P0   = 2'd1,
        GRANT_P1   = 2'd2
    } bank_grant_e;

endpackage

// File: rtl/bcl_addr_split.sv
`timescale 1ns/1ps
module bcl_addr_split #(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 4,
    parameter int WB_W   = 2,
    parameter int SET_W  = 2,
    parameter int BANK_W = 3,
    parameter int TAG_W  = ADDR_W - OFF_W - SET_W - BANK_W
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [TAG_W-1:0]      tag,
    output logic [BANK_W-1:0]     bank,
    output logic [SET_W-1:0]      set,
    output logic [OFF_W-WB_W-1:0] word_idx,
    output logic [WB_W-1:0]       byte_idx,
    output logic [ADDR_W-1:0]     line_addr
);
    assign byte_idx  = addr[WB_W-1:0];
    assign word_idx  = addr[OFF_W-1:WB_W];
    assign set       = addr[OFF_W +: SET_W];
    assign bank      = addr[OFF_W+SET_W +: BANK_W];
    assign tag       = addr[ADDR_W-1 -: TAG_W];
    assign line_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/bcl_bank.sv
`timescale 1ns/1ps
module bcl_bank #(
    parameter int SETS   = 4,
    parameter int WAYS   = 8,
    parameter int TAG_W  = 55,
    parameter int LINE_W = 128,
    parameter int SET_W  = $clog2(SETS),
    parameter int WAY_W  = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0]              rd_vld,
    output logic [WAYS-1:0][LINE_W-1:0]  rd_line,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [LINE_W-1:0]            wr_line
);
    logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [LINE_W-1:0] line_mem [SETS][WAYS];
    logic [WAYS-1:0]   vld_q    [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_set][wr_way]  <= wr_tag;
            line_mem[wr_set][wr_way] <= wr_line;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w]  = tag_mem[rd_set][w];
            rd_line[w] = line_mem[rd_set][w];
            rd_vld[w]  = vld_q[rd_set][w];
        end
    end

    // R9: a written way is valid on the following cycle
    p_fill_valid_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/bcl_way_select.sv
`timescale 1ns/1ps
module bcl_way_select #(
    parameter int WAYS   = 8,
    parameter int TAG_W  = 55,
    parameter int LINE_W = 128,
    parameter int WORD_W = 32,
    parameter int WI_W   = 2,
    parameter int BI_W   = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    input  logic [WAYS-1:0]              way_vld,
    input  logic [WAYS-1:0][LINE_W-1:0]  way_line,
    input  logic [TAG_W-1:0]             req_tag,
    input  logic [WI_W-1:0]              word_idx,
    input  logic [BI_W-1:0]              byte_idx,
    output logic                         hit,
    output logic                         multi,
    output logic [WORD_W-1:0]            word_o,
    output logic [7:0]                   byte_o
);
    logic [WAYS-1:0]   match;
    logic [WAYS-1:0]   sel;
    logic [LINE_W-1:0] line_sel;
    logic              found;

    // XOR compare reduced to zero, qualified by valid
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_vld[w] & ~(|(way_tag[w] ^ req_tag));
    end

    // One-hot driver: lowest-numbered matching way only
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w] && !found) begin
                sel[w] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign hit   = |match;
    assign multi = |(match & (match - WAYS'(1)));

    // Stage 1: line of the selected way; unselected ways add zero
    always_comb begin
        line_sel = '0;
        for (int w = 0; w < WAYS; w++)
            line_sel = line_sel | (way_line[w] & {LINE_W{sel[w]}});
    end

    // Stage 2: word, stage 3: byte
    assign word_o = line_sel[word_idx * WORD_W +: WORD_W];
    assign byte_o = word_o[byte_idx * 8 +: 8];
endmodule

// File: rtl/bcl_top.sv
`timescale 1ns/1ps
module bcl_top
    import bcl_pkg::*;
#(
    parameter int ADDR_W        = DEF_ADDR_W,
    parameter int NUM_BANKS     = DEF_BANKS,
    parameter int SETS_PER_BANK = DEF_SETS,
    parameter int WAYS          = DEF_WAYS,
    parameter int LINE_BYTES    = DEF_LINE_BYTES,
    parameter int WORD_BYTES    = DEF_WORD_BYTES,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int WB_W   = $clog2(WORD_BYTES),
    localparam int WI_W   = OFF_W - WB_W,
    localparam int SET_W  = $clog2(SETS_PER_BANK),
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W - BANK_W,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WORD_W = WORD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rq0_valid,
    input  logic [ADDR_W-1:0] rq0_addr,
    input  logic              rq1_valid,
    input  logic [ADDR_W-1:0] rq1_addr,
    output logic              rq1_ready,
    output logic              rs0_valid,
    output logic              rs0_hit,
    output logic              rs0_multi,
    output logic [WORD_W-1:0] rs0_word,
    output logic [7:0]        rs0_byte,
    output logic              mq0_valid,
    output logic [ADDR_W-1:0] mq0_addr,
    output logic              rs1_valid,
    output logic              rs1_hit,
    output logic              rs1_multi,
    output logic [WORD_W-1:0] rs1_word,
    output logic [7:0]        rs1_byte,
    output logic              mq1_valid,
    output logic [ADDR_W-1:0] mq1_addr,
    input  logic              fl_valid,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [WAY_W-1:0]  fl_way,
    input  logic [LINE_W-1:0] fl_line
);
    // ---------------- request side ----------------
    logic              req_v    [NUM_PORTS];
    logic [ADDR_W-1:0] req_a    [NUM_PORTS];
    logic [TAG_W-1:0]  req_tag  [NUM_PORTS];
    logic [BANK_W-1:0] req_bank [NUM_PORTS];
    logic [SET_W-1:0]  req_set  [NUM_PORTS];
    logic [WI_W-1:0]   req_wi   [NUM_PORTS];
    logic [WB_W-1:0]   req_bi   [NUM_PORTS];
    logic [ADDR_W-1:0] req_line [NUM_PORTS];
    logic              acc      [NUM_PORTS];
    logic              clash;

    assign req_v[0] = rq0_valid;
    assign req_v[1] = rq1_valid;
    assign req_a[0] = rq0_addr;
    assign req_a[1] = rq1_addr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_split
        bcl_addr_split #(
            .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WB_W(WB_W),
            .SET_W(SET_W), .BANK_W(BANK_W), .TAG_W(TAG_W)
        ) u_split (
            .addr      (req_a[p]),
            .tag       (req_tag[p]),
            .bank      (req_bank[p]),
            .set       (req_set[p]),
            .word_idx  (req_wi[p]),
            .byte_idx  (req_bi[p]),
            .line_addr (req_line[p])
        );
    end

    // Port 0 has priority on a shared bank
    assign clash     = req_v[0] && req_v[1] && (req_bank[0] == req_bank[1]);
    assign acc[0]    = req_v[0];
    assign acc[1]    = req_v[1] && !clash;
    assign rq1_ready = !clash;

    // ---------------- fill fields ----------------
    logic [TAG_W-1:0]  fl_tag;
    logic [BANK_W-1:0] fl_bank;
    logic [SET_W-1:0]  fl_set;

    assign fl_tag  = fl_addr[ADDR_W-1 -: TAG_W];
    assign fl_bank = fl_addr[OFF_W+SET_W +: BANK_W];
    assign fl_set  = fl_addr[OFF_W +: SET_W];

    // ---------------- banks ----------------
    logic [WAYS-1:0][TAG_W-1:0]  bk_tag  [NUM_BANKS];
    logic [WAYS-1:0]             bk_vld  [NUM_BANKS];
    logic [WAYS-1:0][LINE_W-1:0] bk_line [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_grant_e      grant;
        logic [SET_W-1:0] rd_set;
        logic             fill_here;

        always_comb begin
            if (acc[0] && req_bank[0] == BANK_W'(b))      grant = GRANT_P0;
            else if (acc[1] && req_bank[1] == BANK_W'(b)) grant = GRANT_P1;
            else                                          grant = GRANT_NONE;
            rd_set = (grant == GRANT_P1) ? req_set[1] : req_set[0];
        end

        assign fill_here = fl_valid && (fl_bank == BANK_W'(b));

        bcl_bank #(
            .SETS(SETS_PER_BANK), .WAYS(WAYS), .TAG_W(TAG_W),
            .LINE_W(LINE_W), .SET_W(SET_W), .WAY_W(WAY_W)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .rd_set  (rd_set),
            .rd_tag  (bk_tag[b]),
            .rd_vld  (bk_vld[b]),
            .rd_line (bk_line[b]),
            .wr_en   (fill_here),
            .wr_set  (fl_set),
            .wr_way  (fl_way),
            .wr_tag  (fl_tag),
            .wr_line (fl_line)
        );
    end

    // ---------------- per-port select and response ----------------
    logic              o_v     [NUM_PORTS];
    logic              o_hit   [NUM_PORTS];
    logic              o_multi [NUM_PORTS];
    logic [WORD_W-1:0] o_word  [NUM_PORTS];
    logic [7:0]        o_byte  [NUM_PORTS];
    logic              o_mq    [NUM_PORTS];
    logic [ADDR_W-1:0] o_mqa   [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic              hit_c, multi_c;
        logic [WORD_W-1:0] word_c;
        logic [7:0]        byte_c;
        logic              rs_v_q, rs_hit_q, rs_multi_q, mq_v_q;
        logic [WORD_W-1:0] rs_word_q;
        logic [7:0]        rs_byte_q;
        logic [ADDR_W-1:0] mq_a_q;

        bcl_way_select #(
            .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W),
            .WORD_W(WORD_W), .WI_W(WI_W), .BI_W(WB_W)
        ) u_sel (
            .way_tag  (bk_tag[req_bank[p]]),
            .way_vld  (bk_vld[req_bank[p]]),
            .way_line (bk_line[req_bank[p]]),
            .req_tag  (req_tag[p]),
            .word_idx (req_wi[p]),
            .byte_idx (req_bi[p]),
            .hit      (hit_c),
            .multi    (multi_c),
            .word_o   (word_c),
            .byte_o   (byte_c)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                rs_v_q     <= 1'b0;
                rs_hit_q   <= 1'b0;
                rs_multi_q <= 1'b0;
                rs_word_q  <= '0;
                rs_byte_q  <= '0;
                mq_v_q     <= 1'b0;
                mq_a_q     <= '0;
            end else begin
                rs_v_q     <= acc[p];
                rs_hit_q   <= acc[p] && hit_c;
                rs_multi_q <= acc[p] && multi_c;
                rs_word_q  <= (acc[p] && hit_c) ? word_c : '0;
                rs_byte_q  <= (acc[p] && hit_c) ? byte_c : '0;
                mq_v_q     <= acc[p] && !hit_c;
                mq_a_q     <= req_line[p];
            end
        end

        assign o_v[p]     = rs_v_q;
        assign o_hit[p]   = rs_hit_q;
        assign o_multi[p] = rs_multi_q;
        assign o_word[p]  = rs_word_q;
        assign o_byte[p]  = rs_byte_q;
        assign o_mq[p]    = mq_v_q;
        assign o_mqa[p]   = mq_a_q;

        // R6: one-cycle response to an accepted request, none otherwise
        p_latency_r6: assert property (@(posedge clk) disable iff (rst)
            acc[p] |=> rs_v_q);
        p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
            !acc[p] |=> !rs_v_q);
        // R5: exactly one outcome per response
        p_one_outcome_r5: assert property (@(posedge clk) disable iff (rst)
            rs_v_q |-> (rs_hit_q != mq_v_q));
        p_quiet_idle_r5: assert property (@(posedge clk) disable iff (rst)
            !rs_v_q |-> (!rs_hit_q && !mq_v_q));
        // R4: miss drives zero data
        p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
            (rs_v_q && !rs_hit_q) |-> (rs_word_q == '0 && rs_byte_q == '0));
        // R10: multi-hit only accompanies a hit
        p_multi_hit_r10: assert property (@(posedge clk) disable iff (rst)
            rs_multi_q |-> rs_hit_q);
    end

    assign rs0_valid = o_v[0];
    assign rs0_hit   = o_hit[0];
    assign rs0_multi = o_multi[0];
    assign rs0_word  = o_word[0];
    assign rs0_byte  = o_byte[0];
    assign mq0_valid = o_mq[0];
    assign mq0_addr  = o_mqa[0];
    assign rs1_valid = o_v[1];
    assign rs1_hit   = o_hit[1];
    assign rs1_multi = o_multi[1];
    assign rs1_word  = o_word[1];
    assign rs1_byte  = o_byte[1];
    assign mq1_valid = o_mq[1];
    assign mq1_addr  = o_mqa[1];

    // R8: a stalled port-1 request produces no response
    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (rq1_valid && !rq1_ready) |=> !rs1_valid);
endmodule

// File: tb/bcl_top_tb.sv
`timescale 1ns/1ps
module bcl_top_tb;
    localparam int ADDR_W     = 64;
    localparam int NB         = 8;
    localparam int SETS       = 4;
    localparam int WAYS       = 8;
    localparam int LINE_BYTES = 16;
    localparam int WORD_BYTES = 4;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int BANK_W = $clog2(NB);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W - BANK_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORD_W = WORD_BYTES * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rq0_valid = 1'b0, rq1_valid = 1'b0, fl_valid = 1'b0;
    logic [ADDR_W-1:0] rq0_addr = '0, rq1_addr = '0, fl_addr = '0;
    logic [WAY_W-1:0]  fl_way = '0;
    logic [LINE_W-1:0] fl_line = '0;
    logic rq1_ready;
    logic rs0_valid, rs0_hit, rs0_multi, mq0_valid;
    logic rs1_valid, rs1_hit, rs1_multi, mq1_valid;
    logic [WORD_W-1:0] rs0_word, rs1_word;
    logic [7:0] rs0_byte, rs1_byte;
    logic [ADDR_W-1:0] mq0_addr, mq1_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcl_top u_dut (
        .clk(clk), .rst(rst),
        .rq0_valid(rq0_valid), .rq0_addr(rq0_addr),
        .rq1_valid(rq1_valid), .rq1_addr(rq1_addr), .rq1_ready(rq1_ready),
        .rs0_valid(rs0_valid), .rs0_hit(rs0_hit), .rs0_multi(rs0_multi),
        .rs0_word(rs0_word), .rs0_byte(rs0_byte),
        .mq0_valid(mq0_valid), .mq0_addr(mq0_addr),
        .rs1_valid(rs1_valid), .rs1_hit(rs1_hit), .rs1_multi(rs1_multi),
        .rs1_word(rs1_word), .rs1_byte(rs1_byte),
        .mq1_valid(mq1_valid), .mq1_addr(mq1_addr),
        .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_way(fl_way), .fl_line(fl_line)
    );

    // reference contents
    logic [TAG_W-1:0]  m_tag  [NB][SETS][WAYS];
    logic              m_vld  [NB][SETS][WAYS];
    logic [LINE_W-1:0] m_data [NB][SETS][WAYS];

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [TAG_W-1:0] t, input int bk,
                                                  input int st, input int off);
        return {t, BANK_W'(bk), SET_W'(st), OFF_W'(off)};
    endfunction

    function automatic logic [LINE_W-1:0] mk_line(input int base);
        logic [LINE_W-1:0] l;
        for (int i = 0; i < LINE_BYTES; i++) l[i*8 +: 8] = 8'(base + i * 7);
        return l;
    endfunction

    function automatic logic [LINE_W-1:0] rnd_line();
        logic [LINE_W-1:0] l;
        for (int i = 0; i < LINE_W / 32; i++) l[i*32 +: 32] = $urandom;
        return l;
    endfunction

    function automatic int bank_of(input logic [ADDR_W-1:0] a);
        return int'(a[OFF_W+SET_W +: BANK_W]);
    endfunction

    task automatic predict(input logic [ADDR_W-1:0] a, output logic h, output logic m,
                           output logic [WORD_W-1:0] w, output logic [7:0] b);
        int bk, st, off;
        logic [TAG_W-1:0] t;
        t   = a[ADDR_W-1 -: TAG_W];
        bk  = int'(a[OFF_W+SET_W +: BANK_W]);
        st  = int'(a[OFF_W +: SET_W]);
        off = int'(a[OFF_W-1:0]);
        h = 1'b0; m = 1'b0; w = '0; b = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (m_vld[bk][st][i] && m_tag[bk][st][i] == t) begin
                if (!h) begin
                    h = 1'b1;
                    w = m_data[bk][st][i][(off / WORD_BYTES) * WORD_W +: WORD_W];
                    b = m_data[bk][st][i][off * 8 +: 8];
                end else begin
                    m = 1'b1;
                end
            end
        end
    endtask

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) m_vld[b][s][w] = 1'b0;
    endtask

    // One cycle: drive at a falling edge, check ready, check responses at the next falling edge.
    task automatic step(input logic v0, input logic [ADDR_W-1:0] a0,
                        input logic v1, input logic [ADDR_W-1:0] a1,
                        input logic fv, input logic [ADDR_W-1:0] fa,
                        input int fw, input logic [LINE_W-1:0] fd, input string tag_msg);
        logic clash, acc1;
        logic h0, m0, h1, m1;
        logic [WORD_W-1:0] w0, w1;
        logic [7:0] b0, b1;
        rq0_valid = v0; rq0_addr = a0;
        rq1_valid = v1; rq1_addr = a1;
        fl_valid = fv; fl_addr = fa; fl_way = WAY_W'(fw); fl_line = fd;
        #1;
        clash = v0 && v1 && (bank_of(a0) == bank_of(a1));
        acc1  = v1 && !clash;
        chk({"R8 ready ", tag_msg}, 64'(rq1_ready), 64'(!clash));
        predict(a0, h0, m0, w0, b0);
        predict(a1, h1, m1, w1, b1);
        if (fv) begin
            m_tag[bank_of(fa)][int'(fa[OFF_W +: SET_W])][fw]  = fa[ADDR_W-1 -: TAG_W];
            m_vld[bank_of(fa)][int'(fa[OFF_W +: SET_W])][fw]  = 1'b1;
            m_data[bank_of(fa)][int'(fa[OFF_W +: SET_W])][fw] = fd;
        end
        @(posedge clk);
        @(negedge clk);
        chk({"R6 rs0_valid ", tag_msg}, 64'(rs0_valid), 64'(v0));
        if (v0) begin
            chk({"R2 rs0_hit ", tag_msg}, 64'(rs0_hit), 64'(h0));
            chk({"R10 rs0_multi ", tag_msg}, 64'(rs0_multi), 64'(m0));
            chk({"R3 rs0_word ", tag_msg}, 64'(rs0_word), 64'(w0));
            chk({"R3 rs0_byte ", tag_msg}, 64'(rs0_byte), 64'(b0));
            chk({"R5 mq0_valid ", tag_msg}, 64'(mq0_valid), 64'(!h0));
            if (!h0) chk({"R4 mq0_addr ", tag_msg}, mq0_addr, {a0[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});
        end else begin
            chk({"R5 idle p0 ", tag_msg}, 64'({rs0_hit, mq0_valid}), 64'(0));
        end
        chk({"R7 rs1_valid ", tag_msg}, 64'(rs1_valid), 64'(acc1));
        if (acc1) begin
            chk({"R2 rs1_hit ", tag_msg}, 64'(rs1_hit), 64'(h1));
            chk({"R10 rs1_multi ", tag_msg}, 64'(rs1_multi), 64'(m1));
            chk({"R3 rs1_word ", tag_msg}, 64'(rs1_word), 64'(w1));
            chk({"R3 rs1_byte ", tag_msg}, 64'(rs1_byte), 64'(b1));
            chk({"R5 mq1_valid ", tag_msg}, 64'(mq1_valid), 64'(!h1));
            if (!h1) chk({"R4 mq1_addr ", tag_msg}, mq1_addr, {a1[ADDR_W-1:OFF_W], {OFF_W{1'b0}}});
        end else begin
            chk({"R8 idle p1 ", tag_msg}, 64'({rs1_hit, mq1_valid}), 64'(0));
        end
    endtask

    task automatic do_reset();
        rq0_valid = 1'b0; rq1_valid = 1'b0; fl_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R6 watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [TAG_W-1:0] ta, pool [4];
        logic [ADDR_W-1:0] aa;
        void'($urandom(32'h1bad_5eed));
        ta = TAG_W'(55'h12_3456_789a);
        for (int i = 0; i < 4; i++) pool[i] = TAG_W'(i * 32'h1357 + 5);
        aa = mk_addr(ta, 2, 1, 13);

        do_reset();
        // R11: reset state
        chk("R11 rs0_valid after reset", 64'(rs0_valid), 0);
        chk("R11 rs1_valid after reset", 64'(rs1_valid), 0);
        chk("R11 mq0_valid after reset", 64'(mq0_valid), 0);
        chk("R11 rs0_word after reset", 64'(rs0_word), 0);
        step(1, aa, 1, mk_addr(ta, 6, 3, 2), 0, '0, 0, '0, "R11 empty lookups miss");

        // R9: same-cycle fill not seen; R7 different banks together
        step(1, aa, 1, mk_addr(ta, 5, 1, 0), 1, aa, 3, mk_line(8'hA0), "R9 fill same cycle");
        step(1, aa, 1, mk_addr(ta, 5, 1, 0), 0, '0, 0, '0, "R9 fill visible");
        // R1: neighbouring bank / set do not alias
        step(1, mk_addr(ta, 3, 1, 13), 1, mk_addr(ta, 2, 2, 13), 0, '0, 0, '0, "R1 no alias");
        // R8: same bank clash
        step(1, aa, 1, mk_addr(ta, 2, 1, 4), 0, '0, 0, '0, "R8 clash");
        // R10: second matching way
        step(0, '0, 0, '0, 1, aa, 6, mk_line(8'h30), "R10 fill way6");
        step(1, aa, 1, mk_addr(ta, 0, 0, 0), 0, '0, 0, '0, "R10 multi low way3");
        step(0, '0, 0, '0, 1, aa, 1, mk_line(8'h55), "R10 fill way1");
        step(1, mk_addr(ta, 2, 1, 15), 0, '0, 0, '0, 0, '0, "R10 multi low way1");
        // R2: single tag bit differs
        step(1, mk_addr(ta ^ TAG_W'(1), 2, 1, 13), 1, mk_addr(ta ^ {1'b1, {(TAG_W-1){1'b0}}}, 4, 1, 0),
             0, '0, 0, '0, "R2 tag bit");
        // R3: offset extremes
        step(1, mk_addr(ta, 2, 1, 0), 1, mk_addr(ta, 5, 1, 15), 0, '0, 0, '0, "R3 offsets");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic v0, v1, fv;
            logic [ADDR_W-1:0] a0, a1, fa;
            v0 = ($urandom % 4) != 0;
            v1 = ($urandom % 4) != 0;
            fv = ($urandom % 3) == 0;
            a0 = mk_addr(pool[$urandom % 4], int'($urandom % NB), int'($urandom % SETS), int'($urandom % LINE_BYTES));
            a1 = mk_addr(pool[$urandom % 4], int'($urandom % NB), int'($urandom % SETS), int'($urandom % LINE_BYTES));
            fa = mk_addr(pool[$urandom % 4], int'($urandom % NB), int'($urandom % SETS), 0);
            step(v0, a0, v1, a1, fv, fa, int'($urandom % WAYS), rnd_line(), "R7 random");
        end

        // R11: reset mid-run empties the cache
        do_reset();
        step(1, aa, 1, mk_addr(pool[0], 1, 1, 1), 0, '0, 0, '0, "R11 after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule